// File: doc/BRIEF.md
# Speed-Gated Latching Status Register

This block holds a 16-bit read-only status word for a 10/100 Mb/s Ethernet receive path. Six error and condition flags are sticky: each is set by a one-cycle event pulse from a detector elsewhere and stays set until the status word is read or the block is reset. Every sticky flag belongs to one line rate. Two flags are meaningful only at 10 Mb/s (a frame missing its start-of-frame delimiter, a Manchester code violation). Four are meaningful only at 100 Mb/s (disconnect, loss of scrambler lock, false carrier, forced jam). A flag can set only while its own rate is selected, and it reads 0 while the other rate is selected.

One further bit is live and does not latch. It reports that a reversed receive pair has been detected and corrected. It reads 1 only when the polarity-correction enable is set and the rate is 10 Mb/s. The enable is held in a different register and reaches this block as an input. The management interface samples `status_q` in the cycle in which it raises `rd_stb`, and that strobe clears the sticky flags for the cycles that follow.

Top module: `speed_status_reg`

## Requirements
- R1: Bits 15:9 and bits 1:0 of `status_q` always read 0.
- R2: At 10 Mb/s (`speed_100`=0), a pulse on `ev_no_sfd` sets bit 8 of `status_q` one cycle later, and the bit stays set.
- R3: At 10 Mb/s, a pulse on `ev_code_viol` sets bit 7 one cycle later, and the bit stays set.
- R4: At 100 Mb/s (`speed_100`=1), pulses on `ev_disconnect`, `ev_unlock`, `ev_false_carrier` and `ev_force_jam` set bits 5, 4, 3 and 2 respectively, one cycle later, and each bit stays set.
- R5: A set sticky bit stays 1 while no read occurs and the rate does not change. In the cycle after `rd_stb` is high it reads 0, unless R6 applies.
- R6: If a flag's event arrives in the same cycle as `rd_stb`, that flag reads 1 in the next cycle, so the event is not lost.
- R7: Events for the rate that is not selected have no effect. One cycle after a rate is selected, the bits of the other rate read 0, and they stay 0 after a later switch back.
- R8: Bit 6 equals `pol_fix_en & pol_reversed & ~speed_100` as sampled one cycle earlier. It does not latch, and reads do not affect it.
- R9: While `rst` is high at a clock edge, all bits of `status_q` become 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_100 | input | 1 | Rate select: 1 = 100 Mb/s, 0 = 10 Mb/s |
| pol_fix_en | input | 1 | Polarity-correction enable, held in another register |
| pol_reversed | input | 1 | Live indication that a reversed pair was detected and corrected |
| ev_no_sfd | input | 1 | Pulse: frame received without a start-of-frame delimiter (10 Mb/s) |
| ev_code_viol | input | 1 | Pulse: Manchester code violation (10 Mb/s) |
| ev_disconnect | input | 1 | Pulse: disconnect (100 Mb/s) |
| ev_unlock | input | 1 | Pulse: scrambler lost lock (100 Mb/s) |
| ev_false_carrier | input | 1 | Pulse: false carrier (100 Mb/s) |
| ev_force_jam | input | 1 | Pulse: forced jam (100 Mb/s) |
| rd_stb | input | 1 | Status read strobe; clears sticky bits after this cycle |
| status_q | output | 16 | Registered status word |

## Verification
The hardest case to reach is an event that lands in exactly the cycle of the clearing read, especially while other flags are being cleared by that same strobe. A second hard case is a rate switch while flags of the old rate are still latched. The stimulus sweeps every combination of the six event pulses, crossed with both rates and with the read strobe on and off, so that every coincidence of event and read occurs. Directed sequences then latch flags of one rate, switch rates, fire events of the wrong rate, and switch back, to show that the old flags stay gone.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int REG_W     = 16;
  localparam int NUM_FLAGS = 6;
  localparam int POL_POS   = 6;

  // Flag index -> bit position in the status word.
  // 0: no start-of-frame delimiter, 1: code violation, 2: disconnect,
  // 3: scrambler unlock, 4: false carrier, 5: forced jam.
  localparam int FLAG_POS [NUM_FLAGS] = '{8, 7, 5, 4, 3, 2};

  // Flags that belong to the 100 Mb/s rate; the rest belong to 10 Mb/s.
  localparam logic [NUM_FLAGS-1:0] FAST_MASK = 6'b111100;

  typedef enum logic {
    SPD_10  = 1'b0,
    SPD_100 = 1'b1
  } speed_e;
endpackage

// File: rtl/lsr_rate_gate.sv
// Derives, per sticky flag, whether the selected line rate allows it to hold a value.
module lsr_rate_gate #(
  parameter int                    N         = 6,
  parameter logic [N-1:0]          FAST_SEL  = '0
) (
  input  logic          speed_100,
  output logic [N-1:0]  allow
);
  lsr_pkg::speed_e rate;

  always_comb begin
    rate = lsr_pkg::speed_e'(speed_100);
    case (rate)
      lsr_pkg::SPD_100: allow = FAST_SEL;
      default:          allow = ~FAST_SEL;
    endcase
  end
endmodule

// File: rtl/lsr_sticky_bank.sv
// Bank of clear-on-read sticky flags; a coincident event wins over the clear.
module lsr_sticky_bank #(
  parameter int N = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  event_in,
  input  logic [N-1:0]  allow,
  input  logic          rd_clr,
  output logic [N-1:0]  flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic held;
    always_comb held = flag_q[i] & ~rd_clr;

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= allow[i] & (held | event_in[i]);
    end
  end
endmodule

// File: rtl/lsr_live_bit.sv
// Registered, non-latching polarity-correction status.
module lsr_live_bit (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic detected,
  input  logic speed_100,
  output logic live_q
);
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= enable & detected & ~speed_100;
  end
endmodule

// File: rtl/speed_status_reg.sv
module speed_status_reg #(
  parameter int REG_W     = lsr_pkg::REG_W,
  parameter int NUM_FLAGS = lsr_pkg::NUM_FLAGS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             speed_100,
  input  logic             pol_fix_en,
  input  logic             pol_reversed,
  input  logic             ev_no_sfd,
  input  logic             ev_code_viol,
  input  logic             ev_disconnect,
  input  logic             ev_unlock,
  input  logic             ev_false_carrier,
  input  logic             ev_force_jam,
  input  logic             rd_stb,
  output logic [REG_W-1:0] status_q
);
  logic [NUM_FLAGS-1:0] ev_vec;
  logic [NUM_FLAGS-1:0] allow_vec;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 live_q;

  assign ev_vec = {ev_force_jam, ev_false_carrier, ev_unlock,
                   ev_disconnect, ev_code_viol, ev_no_sfd};

  lsr_rate_gate #(
    .N        (NUM_FLAGS),
    .FAST_SEL (lsr_pkg::FAST_MASK)
  ) gate_i (
    .speed_100 (speed_100),
    .allow     (allow_vec)
  );

  lsr_sticky_bank #(
    .N (NUM_FLAGS)
  ) bank_i (
    .clk      (clk),
    .rst      (rst),
    .event_in (ev_vec),
    .allow    (allow_vec),
    .rd_clr   (rd_stb),
    .flag_q   (flag_q)
  );

  lsr_live_bit live_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (pol_fix_en),
    .detected  (pol_reversed),
    .speed_100 (speed_100),
    .live_q    (live_q)
  );

  // Place the registered flags at their word positions; all other bits are 0.
  always_comb begin
    status_q = '0;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      status_q[lsr_pkg::FLAG_POS[i]] = flag_q[i];
    end
    status_q[lsr_pkg::POL_POS] = live_q;
  end
endmodule

// File: rtl/speed_status_reg_checker.sv
module speed_status_reg_checker (
  input logic        clk,
  input logic        rst,
  input logic        speed_100,
  input logic        pol_fix_en,
  input logic        pol_reversed,
  input logic        ev_no_sfd,
  input logic        ev_code_viol,
  input logic        ev_disconnect,
  input logic        ev_force_jam,
  input logic        rd_stb,
  input logic [15:0] status_q
);
  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q[15:9] == 7'd0) && (status_q[1:0] == 2'd0));

  assert_nosfd_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_no_sfd && !speed_100) |=> status_q[8]);

  assert_codeviol_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_code_viol && !speed_100) |=> status_q[7]);

  assert_fast_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_disconnect && ev_force_jam && speed_100) |=> (status_q[5] && status_q[2]));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (status_q[7] && !rd_stb && !speed_100) |=> status_q[7]);

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !ev_code_viol) |=> !status_q[7]);

  assert_coincide_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && ev_disconnect && speed_100) |=> status_q[5]);

  assert_slow_masked_R7: assert property (@(posedge clk) disable iff (rst)
    speed_100 |=> (status_q[8:6] == 3'd0));

  assert_fast_masked_R7: assert property (@(posedge clk) disable iff (rst)
    !speed_100 |=> (status_q[5:2] == 4'd0));

  assert_live_R8: assert property (@(posedge clk) disable iff (rst)
    (pol_fix_en && pol_reversed && !speed_100) |=> status_q[6]);

  assert_live_off_R8: assert property (@(posedge clk) disable iff (rst)
    !pol_fix_en |=> !status_q[6]);
endmodule

bind speed_status_reg speed_status_reg_checker chk_i (
  .clk          (clk),
  .rst          (rst),
  .speed_100    (speed_100),
  .pol_fix_en   (pol_fix_en),
  .pol_reversed (pol_reversed),
  .ev_no_sfd    (ev_no_sfd),
  .ev_code_viol (ev_code_viol),
  .ev_disconnect(ev_disconnect),
  .ev_force_jam (ev_force_jam),
  .rd_stb       (rd_stb),
  .status_q     (status_q)
);

// File: tb/speed_status_reg_tb_top.sv
`timescale 1ns/1ps
module speed_status_reg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic speed_100 = 1'b0, pol_fix_en = 1'b0, pol_reversed = 1'b0;
  logic [5:0] ev = '0;
  logic rd_stb = 1'b0;
  logic [15:0] status_q;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_word = '0;

  always #5 clk = ~clk;

  speed_status_reg dut_i (
    .clk(clk), .rst(rst), .speed_100(speed_100),
    .pol_fix_en(pol_fix_en), .pol_reversed(pol_reversed),
    .ev_no_sfd(ev[0]), .ev_code_viol(ev[1]), .ev_disconnect(ev[2]),
    .ev_unlock(ev[3]), .ev_false_carrier(ev[4]), .ev_force_jam(ev[5]),
    .rd_stb(rd_stb), .status_q(status_q)
  );

  localparam logic [15:0] SLOW_BITS = 16'h0180;  // bits 8,7
  localparam logic [15:0] FAST_BITS = 16'h003C;  // bits 5..2

  function automatic logic [15:0] ev_word(input logic [5:0] e);
    return {7'd0, e[0], e[1], 1'b0, e[2], e[3], e[4], e[5], 2'd0};
  endfunction

  // Expected next word from the requirements.
  function automatic logic [15:0] next_word(input logic [15:0] cur, input logic [5:0] e,
                                            input logic spd, input logic rd,
                                            input logic en, input logic rev);
    logic [15:0] allow, sticky;
    allow  = spd ? FAST_BITS : SLOW_BITS;
    sticky = allow & (((cur & ~16'h0040) & (rd ? 16'h0 : 16'hFFFF)) | ev_word(e));
    return sticky | {9'd0, en & rev & ~spd, 6'd0};
  endfunction

  task automatic check(input string req, input logic [15:0] mask);
    tests++;
    if ((status_q & mask) !== (exp_word & mask)) begin
      fails++;
      $display("FAIL %s: status_q=%h expected=%h (mask %h)", req,
               status_q & mask, exp_word & mask, mask);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, "/R1"}, 16'hFE03);
    check({tag, "/R2"}, 16'h0100);
    check({tag, "/R3"}, 16'h0080);
    check({tag, "/R4"}, 16'h003C);
    check({tag, "/R8"}, 16'h0040);
  endtask

  // Called at a negedge: drive, clock, update model, check at the next negedge.
  task automatic step(input logic [5:0] e, input logic spd, input logic rd,
                      input logic en, input logic rev, input string tag);
    ev = e; speed_100 = spd; rd_stb = rd; pol_fix_en = en; pol_reversed = rev;
    @(posedge clk);
    exp_word = next_word(exp_word, e, spd, rd, en, rev);
    @(negedge clk);
    ev = '0; rd_stb = 1'b0;
    check_all(tag);
  endtask

  initial begin : watchdog
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    exp_word = '0;
    check("reset R9", 16'hFFFF);

    // Near-exhaustive sweep: rates x event patterns x read strobe.
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 64; e++)
        for (int r = 0; r < 2; r++)
          step(e[5:0], s[0], r[0], e[0], e[1], "sweep");

    // R5: hold without reads, then clear by read.
    step(6'b000011, 1'b0, 1'b0, 1'b0, 1'b0, "R5 set");
    for (int k = 0; k < 4; k++) step(6'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 hold");
    step(6'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 read");
    check("R5 cleared", 16'hFFFF);

    // R6: event coincident with clearing read, others cleared by same read.
    step(6'b111100, 1'b1, 1'b0, 1'b0, 1'b0, "R6 pre");
    step(6'b000100, 1'b1, 1'b1, 1'b0, 1'b0, "R6 coincide");
    check("R6 only bit5", 16'hFFFF);

    // R7: switch rates with fast flags latched; wrong-rate events ignored.
    step(6'b111100, 1'b1, 1'b0, 1'b0, 1'b0, "R7 latch");
    step(6'b111100, 1'b0, 1'b0, 1'b1, 1'b1, "R7 switch");
    step(6'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 back");
    check("R7 old flags gone", 16'hFFFF);
    step(6'b000011, 1'b1, 1'b0, 1'b1, 1'b1, "R7 slow ignored");

    // R8: live bit follows inputs, unaffected by reads.
    step(6'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R8 on with read");
    step(6'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 drops");
    step(6'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 disabled");

    // R9: reset with flags set.
    step(6'b000011, 1'b0, 1'b0, 1'b1, 1'b1, "R9 pre");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    exp_word = '0;
    check("R9 mid-run reset", 16'hFFFF);
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule